// File: doc/BRIEF.md
# Button Sequence Combination Lock

This block watches four push-button levels and recognises a secret four-press order. The order comes from a 4x4 assignment map. Each map row stands for one step of the sequence, and each column stands for one button. When the whole order is keyed in correctly, a persistent lock flag flips. One correct entry sets the lock, and the next correct entry clears it again. A status indicator output is lit whenever the lock is set.

The button levels first pass through a synchroniser. After that, only the moment a button goes from released to pressed counts as a press. Any press that does not match the expected button throws away all progress, so entry restarts at step one. The block carries no data stream. The button inputs, the code map and both outputs are plain level signals with no handshake, and the block never stalls its inputs.

Top module: `btn_seq_lock`

## Requirements
- R1: While reset is asserted and after it is released, the lock flag and indicator are 0 and sequence progress is at step one.
- R2: Bit 4*p+b of the code map set means button b (bit b of the button vector) is expected at step p, where step 0 is the first press. For example, 16'h8412 encodes the order button 1, button 0, button 2, button 3.
- R3: A press is a 0-to-1 change of a synchronised button level. A button held for many cycles counts as exactly one press.
- R4: Four presses that match the map in order toggle the lock flag. A second correct entry toggles it back.
- R5: A wrong press clears all progress. A wrong press is a new press of an unexpected button, or new presses of two or more buttons in the same cycle. The wrong press itself is not taken as a first step.
- R6: After a completed entry, progress returns to step one, so the next toggle needs four fresh presses.
- R7: If any row or any column of the map does not hold exactly one set bit, no entry ever completes and the lock flag never changes.
- R8: The indicator output always equals the lock flag.
- R9: The lock flag changes on the third rising clock edge after the final button level rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common sampling clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears progress and lock |
| btn_i | input | 4 | Raw button levels, 1 = pressed, asynchronous |
| code_map_i | input | 16 | Step/button assignment map, row p in bits 4p+3..4p |
| lock_set_o | output | 1 | Lock flag, 1 = set |
| led_o | output | 1 | Status indicator, lit while set |

## Verification
The sequence logic is driven with two distinct valid maps, so a design that ignores the map cannot pass both. Several kinds of bad entry are also applied: a wrong button partway through, a wrong button on the first step, two buttons at once, the correct button repeated, and maps with a doubled or a missing assignment. Each of these must leave the flag alone. A long hold, a reset in the middle of an entry and a cycle-exact watch of the final press separate edge detection, reset clearing and pipeline latency from plain sequence matching.

// File: rtl/seqlock_pkg.sv
package seqlock_pkg;
  parameter int KEYS        = 4;
  parameter int SYNC_STAGES = 2;
  typedef logic [KEYS-1:0] key_vec_t;
endpackage

// File: rtl/seqlock_press.sv
module seqlock_press #(
  parameter int N     = seqlock_pkg::KEYS,
  parameter int DEPTH = seqlock_pkg::SYNC_STAGES
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] press_o
);
  logic [N-1:0] chain [DEPTH];
  logic [N-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) chain[i] <= '0;
      prev <= '0;
    end else begin
      chain[0] <= lvl_i;
      for (int i = 1; i < DEPTH; i++) chain[i] <= chain[i-1];
      prev <= chain[DEPTH-1];
    end
  end

  // new press only on a released-to-pressed change
  assign press_o = chain[DEPTH-1] & ~prev;

  AST_PRESS_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (press_o != '0) |=> ((press_o & $past(press_o)) == '0)); // R3
endmodule

// File: rtl/seqlock_cfg.sv
module seqlock_cfg #(
  parameter int N = seqlock_pkg::KEYS
) (
  input  logic [N*N-1:0] map_i,
  output logic           cfg_ok_o
);
  logic [N-1:0] row_ok;
  logic [N-1:0] col_ok;

  generate
    for (genvar p = 0; p < N; p++) begin : g_row
      assign row_ok[p] = ($countones(map_i[p*N +: N]) == 1);
    end
    for (genvar b = 0; b < N; b++) begin : g_col
      logic [N-1:0] col;
      for (genvar p = 0; p < N; p++) begin : g_bit
        assign col[p] = map_i[p*N + b];
      end
      assign col_ok[b] = ($countones(col) == 1);
    end
  endgenerate

  assign cfg_ok_o = (&row_ok) & (&col_ok);
endmodule

// File: rtl/seqlock_track.sv
module seqlock_track #(
  parameter int N  = seqlock_pkg::KEYS,
  parameter int SW = $clog2(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   press_i,
  input  logic [N*N-1:0] map_i,
  input  logic           cfg_ok_i,
  output logic           lock_o
);
  localparam logic [SW-1:0] LAST = SW'(N - 1);

  logic [SW-1:0] stage;
  logic          any;
  logic          hit;
  logic [N-1:0]  want;

  always_comb begin
    want = map_i[stage*N +: N];
    any  = |press_i;
    hit  = any && cfg_ok_i && (press_i == want);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage  <= '0;
      lock_o <= 1'b0;
    end else if (any) begin
      if (!hit) begin
        stage <= '0;
      end else if (stage == LAST) begin
        stage  <= '0;
        lock_o <= ~lock_o;
      end else begin
        stage <= stage + 1'b1;
      end
    end
  end

  AST_WRONG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (any && !hit) |=> (stage == '0)); // R5
  AST_HIT_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && stage != LAST) |=> (stage == $past(stage) + 1'b1)); // R4
  AST_FINAL_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && stage == LAST) |=> (lock_o != $past(lock_o) && stage == '0)); // R6
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && stage == LAST) |=> $stable(lock_o)); // R4
  AST_BAD_MAP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_ok_i |-> !hit); // R7
endmodule

// File: rtl/btn_seq_lock.sv
module btn_seq_lock #(
  parameter int N     = seqlock_pkg::KEYS,
  parameter int DEPTH = seqlock_pkg::SYNC_STAGES
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   btn_i,
  input  logic [N*N-1:0] code_map_i,
  output logic           lock_set_o,
  output logic           led_o
);
  logic [N-1:0] press;
  logic         cfg_ok;

  seqlock_press #(.N(N), .DEPTH(DEPTH)) u_press (
    .clk(clk), .rst_n(rst_n), .lvl_i(btn_i), .press_o(press)
  );

  seqlock_cfg #(.N(N)) u_cfg (
    .map_i(code_map_i), .cfg_ok_o(cfg_ok)
  );

  seqlock_track #(.N(N)) u_track (
    .clk(clk), .rst_n(rst_n), .press_i(press), .map_i(code_map_i),
    .cfg_ok_i(cfg_ok), .lock_o(lock_set_o)
  );

  assign led_o = lock_set_o;
endmodule

// File: tb/sim_btn_seq_lock.sv
`timescale 1ns/1ps
module sim_btn_seq_lock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  btn = '0;
  logic [15:0] map = 16'h8412;
  logic        lock, led;
  int          errors = 0;
  int          checks = 0;
  logic        exp_lock = 1'b0;

  always #2 clk = ~clk;

  btn_seq_lock u0 (
    .clk(clk), .rst_n(rst_n), .btn_i(btn), .code_map_i(map),
    .lock_set_o(lock), .led_o(led)
  );

  // {map, six press masks (first in the high nibble), toggle expected}
  localparam logic [40:0] VEC [9] = '{
    {16'h8412, 4'h2, 4'h1, 4'h4, 4'h8, 4'h0, 4'h0, 1'b1}, // R4 set
    {16'h8412, 4'h2, 4'h1, 4'h4, 4'h8, 4'h0, 4'h0, 1'b1}, // R4 unset
    {16'h8412, 4'h2, 4'h1, 4'h8, 4'h1, 4'h0, 4'h0, 1'b0}, // R5 wrong mid, wrong first
    {16'h8412, 4'h2, 4'h4, 4'h2, 4'h1, 4'h4, 4'h8, 1'b1}, // R5 restart then succeed
    {16'h8412, 4'h2, 4'h1, 4'hC, 4'h4, 4'h8, 4'h0, 1'b0}, // R5 two at once
    {16'h8413, 4'h2, 4'h1, 4'h4, 4'h8, 4'h0, 4'h0, 1'b0}, // R7 doubled step
    {16'h8402, 4'h2, 4'h1, 4'h4, 4'h8, 4'h0, 4'h0, 1'b0}, // R7 missing step
    {16'h1248, 4'h8, 4'h4, 4'h2, 4'h1, 4'h0, 4'h0, 1'b1}, // R2 other order
    {16'h1248, 4'h8, 4'h8, 4'h4, 4'h2, 4'h1, 4'h0, 1'b0}  // R3 repeat is wrong
  };

  task automatic chk(input string req, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, expv);
    end
  endtask

  task automatic push(input logic [3:0] m, input int hold);
    if (m != 4'h0) begin
      @(negedge clk) btn = m;
      repeat (hold) @(negedge clk);
      btn = 4'h0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 lock in reset", lock, 1'b0);
    chk("R8 led in reset", led, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 lock after reset", lock, 1'b0);

    for (int v = 0; v < 9; v++) begin
      map = VEC[v][40:25];
      for (int s = 0; s < 6; s++) push(VEC[v][24-4*s -: 4], 3);
      exp_lock = exp_lock ^ VEC[v][0];
      chk($sformatf("R4/R5/R7 vector %0d lock", v), lock, exp_lock);
      chk($sformatf("R8 vector %0d led", v), led, exp_lock);
    end

    // R3: a long hold of the first button counts once
    map = 16'h8412;
    push(4'h2, 20);
    push(4'h1, 3);
    push(4'h4, 3);
    chk("R4 no toggle after three presses", lock, exp_lock);
    push(4'h8, 3);
    exp_lock = ~exp_lock;
    chk("R3 held button counted once", lock, exp_lock);

    // R9: exact latency of the final press
    push(4'h2, 3); push(4'h1, 3); push(4'h4, 3);
    @(negedge clk) btn = 4'h8;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R9 unchanged after two edges", lock, exp_lock);
    @(negedge clk);
    chk("R9 toggled on third edge", lock, ~exp_lock);
    exp_lock = ~exp_lock;
    btn = 4'h0;
    repeat (4) @(negedge clk);

    // R6: leftover last button alone does nothing
    push(4'h8, 3);
    chk("R6 progress cleared after toggle", lock, exp_lock);

    // R1: reset in mid-entry clears lock and progress
    push(4'h2, 3); push(4'h1, 3); push(4'h4, 3);
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk);
    chk("R1 lock cleared by reset", lock, 1'b0);
    rst_n = 1'b1;
    exp_lock = 1'b0;
    push(4'h8, 3);
    chk("R1 progress cleared by reset", lock, 1'b0);
    push(4'h2, 3); push(4'h1, 3); push(4'h4, 3); push(4'h8, 3);
    chk("R4 set after reset", lock, 1'b1);
    chk("R8 led lit when set", led, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule